// File: doc/BRIEF.md
# Platform Health and Intrusion Monitor

This block watches a platform for three faults and reports them through a small register port. After the main reset is released, a watchdog counts down a programmable number of clock cycles while it waits for the processor's first instruction fetch. If the count runs out once, a first-timeout status bit is set and the count starts again. If it runs out a second time with still no fetch, the block drives its platform reset output low for a fixed number of cycles. The first read from the boot flash after reset is compared against the erased value. A match flags the flash as unprogrammed.

A chassis-open switch feeds an active-low input. The input is synchronised and then debounced on a slow real-time-clock enable. Once it is accepted, it sets a sticky intrusion bit. A two-bit routing field turns that bit into a system-management interrupt, a normal interrupt, or no interrupt. The intrusion logic, the routing field and the watchdog reload register are reset only by the always-on reset. They therefore keep their state while the main reset cycles the rest of the platform.

Top module: `plat_guard`

## Requirements
- R1: One clock after main reset is released, the watchdog loads the effective reload value N. If no fetch arrives, status bit 0 (first timeout) becomes 1 after edge N+1, where edge 1 is the first edge after release, and the count restarts from N.
- R2: If no fetch arrives by edge 2N+1, that edge sets status bit 1 (second timeout) and drives `plat_rst_n` low.
- R3: A `fetch_strobe` seen in any cycle up to and including a timeout edge stops the watchdog for good. A fetch at or before edge N+1 sets no timeout bit. A fetch at or before edge 2N+1 prevents bit 1 and the reset pulse.
- R4: `plat_rst_n` stays low for exactly RST_CYCLES clock cycles (16 by default) and then returns high.
- R5: The reload register at address 2 resets to WDT_DEFAULT and reads back exactly what was written. A stored value of 0 acts as a reload of 1.
- R6: Only the first `boot_rd_valid` beat after main reset is examined. A data value of FFh sets status bit 2 (blank flash), and every later beat is ignored.
- R7: With DEB_TICKS = 2, an intrusion is accepted only when two consecutive `rtc_tick` pulses both sample `case_open_n` low after synchronisation. An inactive sample in between restarts the count.
- R8: An accepted intrusion sets status bit 3, which stays set, including through main reset. Only the always-on reset or a clear write removes it.
- R9: Control field bits [1:0] at address 1 route bit 3: 01 drives `irq_o`, 10 drives `smi_o`, and 00 or 11 drive neither output.
- R10: Writing 1 to a status bit at address 0 clears it. Writing 0 leaves it unchanged.
- R11: After reset, status and control read 0, `plat_rst_n` is high, and `smi_o` and `irq_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Main reset, active low |
| aon_rst_n | input | 1 | Always-on reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 status, 1 control, 2 reload) |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Register read data for `reg_addr` |
| fetch_strobe | input | 1 | Processor first-fetch indication |
| boot_rd_valid | input | 1 | Boot flash read data valid |
| boot_rd_data | input | 8 | Boot flash read data |
| case_open_n | input | 1 | Chassis switch, low when opened |
| rtc_tick | input | 1 | One-cycle slow clock enable |
| plat_rst_n | output | 1 | Platform reset output, active low |
| smi_o | output | 1 | System-management interrupt request |
| irq_o | output | 1 | Normal interrupt request |

## Verification
The bench builds the block with WDT_W = 8 and WDT_DEFAULT = 12, and keeps RST_CYCLES = 16 and DEB_TICKS = 2. The short reload lets each run reach both timeouts and the whole reset pulse within a few dozen cycles. This allows many watchdog runs with random reload values and fetch positions, including fetches that land exactly on a timeout edge. Writing zero to the reload register brings the one-cycle count within reach.

// File: rtl/plat_guard_pkg.sv
package plat_guard_pkg;
   localparam logic [1:0] ADDR_STATUS = 2'd0;
   localparam logic [1:0] ADDR_CTRL   = 2'd1;
   localparam logic [1:0] ADDR_RELOAD = 2'd2;

   localparam int STS_TO1   = 0;
   localparam int STS_TO2   = 1;
   localparam int STS_BLANK = 2;
   localparam int STS_INTR  = 3;

   localparam logic [7:0] BLANK_BYTE = 8'hFF;

   typedef enum logic [1:0] {
      ROUTE_NONE = 2'b00,
      ROUTE_IRQ  = 2'b01,
      ROUTE_SMI  = 2'b10,
      ROUTE_RSVD = 2'b11
   } route_e;

   typedef enum logic [1:0] {
      WD_ARM  = 2'd0,
      WD_RUN1 = 2'd1,
      WD_RUN2 = 2'd2,
      WD_DONE = 2'd3
   } wd_state_e;
endpackage

// File: rtl/plat_guard_wdog.sv
module plat_guard_wdog
   import plat_guard_pkg::*;
#(
   parameter int WDT_W      = 16,
   parameter int RST_CYCLES = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fetch,
   input  logic [WDT_W-1:0] reload,
   output logic             to1,
   output logic             to2,
   output logic             plat_rst_n
);
   localparam int PW = $clog2(RST_CYCLES + 1);
   localparam logic [PW-1:0] PULSE_LEN = PW'(RST_CYCLES);

   wd_state_e        state_q;
   logic [WDT_W-1:0] cnt_q;
   logic [PW-1:0]    pulse_q;
   logic             expire;

   assign expire = (cnt_q == WDT_W'(1)) && !fetch;
   assign to1 = (state_q == WD_RUN1) && expire;
   assign to2 = (state_q == WD_RUN2) && expire;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= WD_ARM;
         cnt_q   <= '0;
      end else begin
         unique case (state_q)
            WD_ARM: begin
               if (fetch) state_q <= WD_DONE;
               else begin
                  cnt_q   <= reload;
                  state_q <= WD_RUN1;
               end
            end
            WD_RUN1, WD_RUN2: begin
               if (fetch) state_q <= WD_DONE;
               else if (expire) begin
                  cnt_q   <= reload;
                  state_q <= (state_q == WD_RUN1) ? WD_RUN2 : WD_DONE;
               end else cnt_q <= cnt_q - WDT_W'(1);
            end
            default: state_q <= WD_DONE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pulse_q <= '0;
      else if (to2) pulse_q <= PULSE_LEN;
      else if (pulse_q != '0) pulse_q <= pulse_q - PW'(1);
   end

   assign plat_rst_n = (pulse_q == '0);
endmodule

// File: rtl/plat_guard_intr.sv
module plat_guard_intr #(
   parameter int SYNC_STAGES = 2,
   parameter int DEB_TICKS   = 2
) (
   input  logic clk,
   input  logic aon_rst_n,
   input  logic case_open_n,
   input  logic rtc_tick,
   output logic accept
);
   localparam int CW = $clog2(DEB_TICKS + 1);
   localparam logic [CW-1:0] DEB_FULL = CW'(DEB_TICKS);
   localparam logic [CW-1:0] DEB_LAST = CW'(DEB_TICKS - 1);

   logic pin_s;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign pin_s = case_open_n;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge aon_rst_n) begin
            if (!aon_rst_n) chain_q <= '1;
            else chain_q <= {chain_q[SYNC_STAGES-2:0], case_open_n};
         end
         assign pin_s = chain_q[SYNC_STAGES-1];
      end
   endgenerate

   logic [CW-1:0] deb_q;

   always_ff @(posedge clk or negedge aon_rst_n) begin
      if (!aon_rst_n) deb_q <= '0;
      else if (rtc_tick) begin
         if (pin_s) deb_q <= '0;
         else if (deb_q != DEB_FULL) deb_q <= deb_q + CW'(1);
      end
   end

   assign accept = rtc_tick && !pin_s && (deb_q == DEB_LAST);
endmodule

// File: rtl/plat_guard.sv
module plat_guard
   import plat_guard_pkg::*;
#(
   parameter int REG_W       = 16,
   parameter int WDT_W       = 16,
   parameter int WDT_DEFAULT = 1000,
   parameter int RST_CYCLES  = 16,
   parameter int SYNC_STAGES = 2,
   parameter int DEB_TICKS   = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             aon_rst_n,
   input  logic             reg_wr,
   input  logic [1:0]       reg_addr,
   input  logic [REG_W-1:0] reg_wdata,
   output logic [REG_W-1:0] reg_rdata,
   input  logic             fetch_strobe,
   input  logic             boot_rd_valid,
   input  logic [7:0]       boot_rd_data,
   input  logic             case_open_n,
   input  logic             rtc_tick,
   output logic             plat_rst_n,
   output logic             smi_o,
   output logic             irq_o
);
   generate
      if (REG_W < 4 || WDT_W > REG_W) begin : g_bad_regw
         $error("plat_guard: REG_W must be >= 4 and >= WDT_W");
      end
      if (WDT_DEFAULT < 1 || WDT_DEFAULT >= (2 ** WDT_W)) begin : g_bad_def
         $error("plat_guard: WDT_DEFAULT must be nonzero and fit WDT_W");
      end
      if (RST_CYCLES < 1 || DEB_TICKS < 1 || SYNC_STAGES == 1) begin : g_bad_cfg
         $error("plat_guard: RST_CYCLES, DEB_TICKS >= 1; SYNC_STAGES 0 or >= 2");
      end
   endgenerate

   logic             wr_sts, wr_ctrl, wr_rel;
   logic [WDT_W-1:0] reload_q, reload_eff;
   route_e           route_q;
   logic             intr_sts, sts_to1, sts_to2, sts_blank, boot_seen;
   logic             to1, to2, intr_acc, clr_intr;

   assign wr_sts   = reg_wr && (reg_addr == ADDR_STATUS);
   assign wr_ctrl  = reg_wr && (reg_addr == ADDR_CTRL);
   assign wr_rel   = reg_wr && (reg_addr == ADDR_RELOAD);
   assign clr_intr = wr_sts && reg_wdata[STS_INTR];
   assign reload_eff = (reload_q == '0) ? WDT_W'(1) : reload_q;

   plat_guard_wdog #(.WDT_W(WDT_W), .RST_CYCLES(RST_CYCLES)) u_wdog (
      .clk(clk), .rst_n(rst_n), .fetch(fetch_strobe), .reload(reload_eff),
      .to1(to1), .to2(to2), .plat_rst_n(plat_rst_n)
   );

   plat_guard_intr #(.SYNC_STAGES(SYNC_STAGES), .DEB_TICKS(DEB_TICKS)) u_intr (
      .clk(clk), .aon_rst_n(aon_rst_n), .case_open_n(case_open_n),
      .rtc_tick(rtc_tick), .accept(intr_acc)
   );

   always_ff @(posedge clk or negedge aon_rst_n) begin
      if (!aon_rst_n) begin
         reload_q <= WDT_W'(WDT_DEFAULT);
         route_q  <= ROUTE_NONE;
         intr_sts <= 1'b0;
      end else begin
         if (wr_rel)  reload_q <= reg_wdata[WDT_W-1:0];
         if (wr_ctrl) route_q  <= route_e'(reg_wdata[1:0]);
         if (intr_acc) intr_sts <= 1'b1;
         else if (clr_intr) intr_sts <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sts_to1   <= 1'b0;
         sts_to2   <= 1'b0;
         sts_blank <= 1'b0;
         boot_seen <= 1'b0;
      end else begin
         if (to1) sts_to1 <= 1'b1;
         else if (wr_sts && reg_wdata[STS_TO1]) sts_to1 <= 1'b0;
         if (to2) sts_to2 <= 1'b1;
         else if (wr_sts && reg_wdata[STS_TO2]) sts_to2 <= 1'b0;
         if (boot_rd_valid && !boot_seen && boot_rd_data == BLANK_BYTE) sts_blank <= 1'b1;
         else if (wr_sts && reg_wdata[STS_BLANK]) sts_blank <= 1'b0;
         if (boot_rd_valid) boot_seen <= 1'b1;
      end
   end

   always_comb begin
      reg_rdata = '0;
      unique case (reg_addr)
         ADDR_STATUS: begin
            reg_rdata[STS_TO1]   = sts_to1;
            reg_rdata[STS_TO2]   = sts_to2;
            reg_rdata[STS_BLANK] = sts_blank;
            reg_rdata[STS_INTR]  = intr_sts;
         end
         ADDR_CTRL:   reg_rdata[1:0] = route_q;
         ADDR_RELOAD: reg_rdata[WDT_W-1:0] = reload_q;
         default:     reg_rdata = '0;
      endcase
   end

   assign smi_o = intr_sts && (route_q == ROUTE_SMI);
   assign irq_o = intr_sts && (route_q == ROUTE_IRQ);
endmodule

// File: rtl/plat_guard_chk.sv
module plat_guard_chk #(
   parameter int RST_CYCLES = 16
) (
   input logic clk,
   input logic rst_n,
   input logic aon_rst_n,
   input logic plat_rst_n,
   input logic smi_o,
   input logic irq_o,
   input logic rtc_tick,
   input logic intr_sts,
   input logic clr_intr,
   input logic sts_to2
);
   localparam int LW = $clog2(RST_CYCLES + 2) + 1;
   logic [LW-1:0] lowc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lowc <= '0;
      else if (!plat_rst_n) lowc <= lowc + LW'(1);
      else lowc <= '0;
   end

   a_r4_pulse_len: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(plat_rst_n) |-> lowc == LW'(RST_CYCLES));
   a_r4_pulse_bound: assert property (@(posedge clk) disable iff (!rst_n)
      lowc <= LW'(RST_CYCLES));
   a_r2_reset_after_to2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(plat_rst_n) |-> sts_to2);
   a_r9_one_route: assert property (@(posedge clk) disable iff (!aon_rst_n)
      !(smi_o && irq_o));
   a_r9_needs_event: assert property (@(posedge clk) disable iff (!aon_rst_n)
      (smi_o || irq_o) |-> intr_sts);
   a_r8_sticky: assert property (@(posedge clk) disable iff (!aon_rst_n)
      (intr_sts && !clr_intr) |=> intr_sts);
   a_r7_on_tick: assert property (@(posedge clk) disable iff (!aon_rst_n)
      $rose(intr_sts) |-> $past(rtc_tick));
endmodule

bind plat_guard plat_guard_chk #(.RST_CYCLES(RST_CYCLES)) u_chk (
   .clk(clk), .rst_n(rst_n), .aon_rst_n(aon_rst_n), .plat_rst_n(plat_rst_n),
   .smi_o(smi_o), .irq_o(irq_o), .rtc_tick(rtc_tick), .intr_sts(intr_sts),
   .clr_intr(clr_intr), .sts_to2(sts_to2)
);

// File: tb/plat_guard_tb_top.sv
module plat_guard_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int REG_W = 16;
   localparam int WDT_W = 8;
   localparam int WDT_DEF = 12;
   localparam int RSTC = 16;

   logic clk = 0, rst_n = 0, aon_rst_n = 0;
   logic reg_wr = 0;
   logic [1:0] reg_addr = 0;
   logic [REG_W-1:0] reg_wdata = 0, reg_rdata;
   logic fetch_strobe = 0, boot_rd_valid = 0, case_open_n = 1, rtc_tick = 0;
   logic [7:0] boot_rd_data = 0;
   logic plat_rst_n, smi_o, irq_o;
   int nchk = 0, nerr = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   plat_guard #(.REG_W(REG_W), .WDT_W(WDT_W), .WDT_DEFAULT(WDT_DEF), .RST_CYCLES(RSTC)) dut_i (
      .clk(clk), .rst_n(rst_n), .aon_rst_n(aon_rst_n), .reg_wr(reg_wr),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .fetch_strobe(fetch_strobe), .boot_rd_valid(boot_rd_valid),
      .boot_rd_data(boot_rd_data), .case_open_n(case_open_n), .rtc_tick(rtc_tick),
      .plat_rst_n(plat_rst_n), .smi_o(smi_o), .irq_o(irq_o)
   );

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(logic [1:0] a, logic [REG_W-1:0] d);
      reg_wr = 1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 0; reg_wdata = 0;
   endtask

   task automatic rd(logic [1:0] a, output logic [REG_W-1:0] d);
      reg_addr = a; #1; d = reg_rdata;
   endtask

   task automatic main_reset();
      rst_n = 0; @(negedge clk); @(negedge clk); rst_n = 1;
   endtask

   task automatic tick();
      rtc_tick = 1; @(negedge clk); rtc_tick = 0; @(negedge clk);
   endtask

   function automatic bit exp_to(int n, int f, int which);
      return (which == 1) ? (f > n + 1) : (f > 2 * n + 1);
   endfunction

   // Watchdog run after main_reset with effective reload n; fetch pulsed before edge f.
   task automatic run_wd(int n, int f, string tag);
      bit t1 = exp_to(n, f, 1), t2 = exp_to(n, f, 2), bad = 0;
      reg_addr = 0;
      for (int k = 1; k <= 2 * n + RSTC + 3; k++) begin
         fetch_strobe = (k == f);
         @(negedge clk);
         if (plat_rst_n !== !(t2 && k >= 2 * n + 1 && k <= 2 * n + RSTC)) bad = 1;
         if (reg_rdata[0] !== (t1 && k >= n + 1)) bad = 1;
         if (reg_rdata[1] !== (t2 && k >= 2 * n + 1)) bad = 1;
      end
      fetch_strobe = 0;
      chk(tag, {31'd0, bad}, 32'd0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      nerr++;
      $display("FAIL bench hung, watchdog expired");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin
      logic [REG_W-1:0] d;
      void'($urandom(32'd20240611));
      @(negedge clk); @(negedge clk);
      aon_rst_n = 1; rst_n = 1;
      #1;
      // R11 reset state
      rd(0, d); chk("R11 status", d, 0);
      rd(1, d); chk("R11 ctrl", d, 0);
      chk("R11 outputs", {plat_rst_n, smi_o, irq_o}, 3'b100);
      rd(2, d); chk("R5 reload default", d, WDT_DEF);
      @(negedge clk);
      // R1 R2 R4 default reload, no fetch
      main_reset(); run_wd(WDT_DEF, 1000, "R1 R2 R4 default run");
      // R3 tie cases
      main_reset(); run_wd(WDT_DEF, WDT_DEF + 1, "R3 fetch on first timeout edge");
      main_reset(); run_wd(WDT_DEF, 2 * WDT_DEF + 1, "R3 fetch on second timeout edge");
      main_reset(); run_wd(WDT_DEF, 1, "R3 fetch during arm");
      // R5 zero reload
      wr(2, 0); rd(2, d); chk("R5 reload readback zero", d, 0);
      main_reset(); run_wd(1, 1000, "R5 zero acts as one");
      // random watchdog runs
      for (int i = 0; i < 8; i++) begin
         int n = 1 + $urandom % 10;
         int f = ($urandom % 4 == 0) ? 1000 : 1 + $urandom % (2 * n + 3);
         wr(2, REG_W'(n)); rd(2, d); chk("R5 reload readback", d, n);
         main_reset(); run_wd(n, f, "R1 R2 R3 R4 random run");
      end
      wr(2, REG_W'(60));
      // R6 boot flash
      for (int i = 0; i < 6; i++) begin
         logic [7:0] b = ($urandom % 2) ? 8'hFF : 8'($urandom % 255);
         main_reset();
         boot_rd_valid = 1; boot_rd_data = b; @(negedge clk);
         boot_rd_data = 8'hFF; @(negedge clk);
         boot_rd_valid = 0;
         rd(0, d); chk("R6 first read only", d[2], b == 8'hFF);
      end
      wr(0, 4); rd(0, d); chk("R10 clear blank", d[2], 0);
      // R7 debounce
      case_open_n = 0; repeat (3) @(negedge clk);
      tick(); rd(0, d); chk("R7 one tick not enough", d[3], 0);
      case_open_n = 1; repeat (3) @(negedge clk); tick();
      case_open_n = 0; repeat (3) @(negedge clk);
      tick(); rd(0, d); chk("R7 restart after inactive", d[3], 0);
      tick(); rd(0, d); chk("R7 R8 accepted on second tick", d[3], 1);
      // R8 survives main reset, R10 write zero no effect
      main_reset(); rd(0, d); chk("R8 survives main reset", d[3], 1);
      wr(0, 0); rd(0, d); chk("R10 write zero keeps bit", d[3], 1);
      // R9 routing
      for (int i = 0; i < 8; i++) begin
         logic [1:0] s = 2'($urandom % 4);
         wr(1, REG_W'(s)); rd(1, d); chk("R9 ctrl readback", d, s);
         chk("R9 smi", smi_o, s == 2'b10);
         chk("R9 irq", irq_o, s == 2'b01);
      end
      wr(1, 2);
      wr(0, 8); rd(0, d); chk("R10 clear intrusion", d[3], 0);
      chk("R9 smi drops after clear", smi_o, 0);
      case_open_n = 1; repeat (3) @(negedge clk); tick();
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end
endmodule